// File: doc/BRIEF.md
# Floating-Point Exponent and Shift-Count Datapath

This block is the exponent side of a floating-point unit. It holds two registers: the result exponent and the shift count that the mantissa side uses for alignment and normalization. Each cycle, an external sequencer supplies small select fields, negate flags and load enables. From these the block forms, for each register, the sum of two multiplexed operands. Either operand of a sum may be negated, but never both.

Operands come from the registers themselves, from the exponents of the three source operands A, B and C, from a fixed set of constants, and from an internal difference: the result exponent minus the shift count. The shift register can also take a leading-zero count of the result mantissa. That count is chosen after the shift adder, so it never passes through an addition.

All exponents and the shift count are EW-bit two's-complement values, with EW = 13 by default. All arithmetic wraps modulo 2^EW.

Top module: `fpu_expo_path`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, both `res_exp` and `shift_amt` become 0 after that edge.
- R2: The first operand of the exponent sum is chosen by `re_op1_sel`: 0 selects the current `res_exp`, 1 selects `a_exp`, 2 selects `b_exp` arithmetically shifted right by one bit (sign kept), and 3 selects zero.
- R3: The second operand of the exponent sum is chosen by `re_op2_sel`: 0 selects the difference `res_exp - shift_amt` of the current registers, 1 selects `b_exp`, 2 selects `c_exp`, and 3 selects a constant.
- R4: The exponent constant is chosen by `re_kon_sel`: 0 gives 0, 1 gives 56, 2 gives the maximum exponent (1023), and 3 gives the overflow-trap bias (1536).
- R5: A set negate flag (`re_op1_neg`, `re_op2_neg`, `sh_op1_neg`, `sh_op2_neg`) replaces its operand by its two's-complement negation before the addition. Sums wrap modulo 2^EW. The two negate flags of one sum are never both 1; this is a usage rule.
- R6: When `re_load` is 1 (and reset is 0), `res_exp` takes the exponent sum at the clock edge. When `re_load` is 0, `res_exp` keeps its value.
- R7: The first operand of the shift sum is chosen by `sh_op1_sel`: 0 selects `res_exp - shift_amt`, 1 selects `b_exp`, 2 selects the current `shift_amt`, and 3 selects zero.
- R8: The second operand of the shift sum is `a_exp` when `sh_op2_sel` is 0, and a constant when it is 1. The constant is chosen by `sh_kon_sel`: codes 0 to 9 give 0, 1, 4, 8, 32, 52, 56, 63, 64 and the minimum exponent (-1022), and codes 10 to 15 give 0.
- R9: When `sh_load` and `sh_use_lzc` are both 1, `shift_amt` takes the zero-extended `lzc_cnt`. The shift sum and its negate flags then have no effect.
- R10: When `sh_load` is 1 and `sh_use_lzc` is 0, `shift_amt` takes the shift sum. When `sh_load` is 0, `shift_amt` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| re_op1_sel | input | 2 | Exponent sum, first operand select |
| re_op1_neg | input | 1 | Negate the first exponent operand |
| re_op2_sel | input | 2 | Exponent sum, second operand select |
| re_kon_sel | input | 2 | Exponent constant select |
| re_op2_neg | input | 1 | Negate the second exponent operand |
| re_load | input | 1 | Write the exponent sum into `res_exp` |
| sh_op1_sel | input | 2 | Shift sum, first operand select |
| sh_op1_neg | input | 1 | Negate the first shift operand |
| sh_op2_sel | input | 1 | Shift sum, second operand select |
| sh_kon_sel | input | 4 | Shift constant select |
| sh_op2_neg | input | 1 | Negate the second shift operand |
| sh_use_lzc | input | 1 | Load the leading-zero count instead of the shift sum |
| sh_load | input | 1 | Write into `shift_amt` |
| a_exp | input | EW | Exponent of operand A |
| b_exp | input | EW | Exponent of operand B |
| c_exp | input | EW | Exponent of operand C |
| lzc_cnt | input | LZW | Leading-zero count of the result mantissa |
| res_exp | output | EW | Result exponent register |
| shift_amt | output | EW | Shift count register |

## Verification
Both registers are outputs, so a wrong operand choice, constant or negation shows at the ports one cycle after the load that uses it. The internal difference `res_exp - shift_amt` feeds both sums. A fault there corrupts every later load that selects it, and once such a load writes the register, the wrong value keeps propagating through the self-referencing selects. A failure to hold shows on the first cycle with the enable low, as a register value that changes.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  typedef enum logic [1:0] {
    RE1_RES   = 2'd0,
    RE1_A     = 2'd1,
    RE1_BHALF = 2'd2,
    RE1_ZERO  = 2'd3
  } re_op1_e;

  typedef enum logic [1:0] {
    RE2_DIFF  = 2'd0,
    RE2_B     = 2'd1,
    RE2_C     = 2'd2,
    RE2_KON   = 2'd3
  } re_op2_e;

  typedef enum logic [1:0] {
    SH1_DIFF  = 2'd0,
    SH1_B     = 2'd1,
    SH1_SHIFT = 2'd2,
    SH1_ZERO  = 2'd3
  } sh_op1_e;

  typedef enum logic {
    SH2_A     = 1'b0,
    SH2_KON   = 1'b1
  } sh_op2_e;

  // Constant table variants
  localparam int KON_VARIANT_EXP   = 0;
  localparam int KON_VARIANT_SHIFT = 1;

  // Number of defined codes in the shift constant table
  localparam int SHIFT_KON_CODES = 10;

endpackage

// File: rtl/fpx_const_gen.sv
module fpx_const_gen #(
  parameter int EW       = 13,
  parameter int SELW     = 4,
  parameter int VARIANT  = 0,
  parameter int MAX_EXP  = 1023,
  parameter int MIN_EXP  = -1022,
  parameter int OVF_BIAS = 1536
) (
  input  logic [SELW-1:0] sel,
  output logic [EW-1:0]   kon
);
  import fpx_pkg::*;

  localparam logic [EW-1:0] K_MAX  = EW'(MAX_EXP);
  localparam logic [EW-1:0] K_MIN  = EW'(MIN_EXP);
  localparam logic [EW-1:0] K_BIAS = EW'(OVF_BIAS);

  generate
    if (VARIANT == KON_VARIANT_EXP) begin : g_exp_table
      always_comb begin
        case (sel[1:0])
          2'd0:    kon = '0;
          2'd1:    kon = EW'(56);
          2'd2:    kon = K_MAX;
          default: kon = K_BIAS;
        endcase
      end
    end else begin : g_shift_table
      always_comb begin
        case (sel)
          SELW'(0): kon = '0;
          SELW'(1): kon = EW'(1);
          SELW'(2): kon = EW'(4);
          SELW'(3): kon = EW'(8);
          SELW'(4): kon = EW'(32);
          SELW'(5): kon = EW'(52);
          SELW'(6): kon = EW'(56);
          SELW'(7): kon = EW'(63);
          SELW'(8): kon = EW'(64);
          SELW'(9): kon = K_MIN;
          default:  kon = '0;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/fpx_sel4.sv
module fpx_sel4 #(
  parameter int EW = 13
) (
  input  logic [1:0]    sel,
  input  logic [EW-1:0] in0,
  input  logic [EW-1:0] in1,
  input  logic [EW-1:0] in2,
  input  logic [EW-1:0] in3,
  output logic [EW-1:0] out
);
  always_comb begin
    case (sel)
      2'd0:    out = in0;
      2'd1:    out = in1;
      2'd2:    out = in2;
      default: out = in3;
    endcase
  end
endmodule

// File: rtl/fpx_negadd.sv
module fpx_negadd #(
  parameter int EW = 13
) (
  input  logic [EW-1:0] opa,
  input  logic [EW-1:0] opb,
  input  logic          neg_a,
  input  logic          neg_b,
  output logic [EW-1:0] sum,
  output logic          both_neg
);
  // Conditional inversion; the +1 of the two's complement rides on carry-in.
  function automatic logic [EW-1:0] cond_inv(input logic [EW-1:0] v, input logic inv);
    return inv ? ~v : v;
  endfunction

  function automatic logic [EW-1:0] add_cin(input logic [EW-1:0] x,
                                            input logic [EW-1:0] y,
                                            input logic          cin);
    logic [EW:0] full;
    full = {1'b0, x} + {1'b0, y} + {{EW{1'b0}}, cin};
    return full[EW-1:0];
  endfunction

  logic [EW-1:0] opa_m, opb_m;
  logic          carry_in;

  assign opa_m    = cond_inv(opa, neg_a);
  assign opb_m    = cond_inv(opb, neg_b);
  assign carry_in = neg_a | neg_b;
  assign sum      = add_cin(opa_m, opb_m, carry_in);
  assign both_neg = neg_a & neg_b;

endmodule

// File: rtl/fpu_expo_path.sv
module fpu_expo_path #(
  parameter int EW       = 13,
  parameter int LZW      = 7,
  parameter int MAX_EXP  = 1023,
  parameter int MIN_EXP  = -1022,
  parameter int OVF_BIAS = 1536
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     re_op1_sel,
  input  logic           re_op1_neg,
  input  logic [1:0]     re_op2_sel,
  input  logic [1:0]     re_kon_sel,
  input  logic           re_op2_neg,
  input  logic           re_load,
  input  logic [1:0]     sh_op1_sel,
  input  logic           sh_op1_neg,
  input  logic           sh_op2_sel,
  input  logic [3:0]     sh_kon_sel,
  input  logic           sh_op2_neg,
  input  logic           sh_use_lzc,
  input  logic           sh_load,
  input  logic [EW-1:0]  a_exp,
  input  logic [EW-1:0]  b_exp,
  input  logic [EW-1:0]  c_exp,
  input  logic [LZW-1:0] lzc_cnt,
  output logic [EW-1:0]  res_exp,
  output logic [EW-1:0]  shift_amt
);
  import fpx_pkg::*;

  localparam int PADW = EW - LZW;

  function automatic logic [EW-1:0] halve_signed(input logic [EW-1:0] v);
    return {v[EW-1], v[EW-1:1]};
  endfunction

  function automatic logic [EW-1:0] diff_of(input logic [EW-1:0] x, input logic [EW-1:0] y);
    return x - y;
  endfunction

  function automatic logic [EW-1:0] widen_lzc(input logic [LZW-1:0] v);
    return {{PADW{1'b0}}, v};
  endfunction

  // Named internal events for the checker
  logic [EW-1:0] diff_exp;
  logic [EW-1:0] b_half;
  logic [EW-1:0] re_kon, sh_kon;
  logic [EW-1:0] re_opa, re_opb, sh_opa, sh_opb;
  logic [EW-1:0] re_sum, sh_sum;
  logic [EW-1:0] sh_next;
  logic [EW-1:0] lzc_wide;
  logic          re_both_neg, sh_both_neg;

  assign diff_exp = diff_of(res_exp, shift_amt);
  assign b_half   = halve_signed(b_exp);
  assign lzc_wide = widen_lzc(lzc_cnt);

  // Constant generators
  fpx_const_gen #(
    .EW(EW), .SELW(2), .VARIANT(KON_VARIANT_EXP),
    .MAX_EXP(MAX_EXP), .MIN_EXP(MIN_EXP), .OVF_BIAS(OVF_BIAS)
  ) u_re_kon (
    .sel(re_kon_sel),
    .kon(re_kon)
  );

  fpx_const_gen #(
    .EW(EW), .SELW(4), .VARIANT(KON_VARIANT_SHIFT),
    .MAX_EXP(MAX_EXP), .MIN_EXP(MIN_EXP), .OVF_BIAS(OVF_BIAS)
  ) u_sh_kon (
    .sel(sh_kon_sel),
    .kon(sh_kon)
  );

  // Exponent operand muxes
  fpx_sel4 #(.EW(EW)) u_re_mux_a (
    .sel(re_op1_sel),
    .in0(res_exp), .in1(a_exp), .in2(b_half), .in3('0),
    .out(re_opa)
  );

  fpx_sel4 #(.EW(EW)) u_re_mux_b (
    .sel(re_op2_sel),
    .in0(diff_exp), .in1(b_exp), .in2(c_exp), .in3(re_kon),
    .out(re_opb)
  );

  // Shift operand muxes
  fpx_sel4 #(.EW(EW)) u_sh_mux_a (
    .sel(sh_op1_sel),
    .in0(diff_exp), .in1(b_exp), .in2(shift_amt), .in3('0),
    .out(sh_opa)
  );

  assign sh_opb = (sh_op2_e'(sh_op2_sel) == SH2_KON) ? sh_kon : a_exp;

  // Adders
  fpx_negadd #(.EW(EW)) u_re_add (
    .opa(re_opa), .opb(re_opb),
    .neg_a(re_op1_neg), .neg_b(re_op2_neg),
    .sum(re_sum), .both_neg(re_both_neg)
  );

  fpx_negadd #(.EW(EW)) u_sh_add (
    .opa(sh_opa), .opb(sh_opb),
    .neg_a(sh_op1_neg), .neg_b(sh_op2_neg),
    .sum(sh_sum), .both_neg(sh_both_neg)
  );

  // Post-adder select: the leading-zero count bypasses the adder
  assign sh_next = sh_use_lzc ? lzc_wide : sh_sum;

  // Registers
  always_ff @(posedge clk) begin
    if (rst) begin
      res_exp <= '0;
    end else if (re_load) begin
      res_exp <= re_sum;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_amt <= '0;
    end else if (sh_load) begin
      shift_amt <= sh_next;
    end
  end

endmodule

// File: rtl/fpx_expo_checker.sv
module fpx_expo_checker #(
  parameter int EW  = 13,
  parameter int LZW = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           re_load,
  input logic           sh_load,
  input logic           sh_use_lzc,
  input logic [LZW-1:0] lzc_cnt,
  input logic [EW-1:0]  res_exp,
  input logic [EW-1:0]  shift_amt,
  input logic [EW-1:0]  re_sum,
  input logic [EW-1:0]  sh_sum,
  input logic           re_both_neg,
  input logic           sh_both_neg
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (res_exp == '0 && shift_amt == '0));

  p_single_neg_exp_r5: assert property (@(posedge clk) disable iff (rst)
    !re_both_neg);

  p_single_neg_shift_r5: assert property (@(posedge clk) disable iff (rst)
    !sh_both_neg);

  p_load_exp_r6: assert property (@(posedge clk) disable iff (rst)
    re_load |=> res_exp == $past(re_sum));

  p_hold_exp_r6: assert property (@(posedge clk) disable iff (rst)
    !re_load |=> $stable(res_exp));

  p_lzc_bypass_r9: assert property (@(posedge clk) disable iff (rst)
    (sh_load && sh_use_lzc) |=> shift_amt == {{(EW-LZW){1'b0}}, $past(lzc_cnt)});

  p_load_shift_r10: assert property (@(posedge clk) disable iff (rst)
    (sh_load && !sh_use_lzc) |=> shift_amt == $past(sh_sum));

  p_hold_shift_r10: assert property (@(posedge clk) disable iff (rst)
    !sh_load |=> $stable(shift_amt));

endmodule

bind fpu_expo_path fpx_expo_checker #(.EW(EW), .LZW(LZW)) u_expo_chk (
  .clk(clk),
  .rst(rst),
  .re_load(re_load),
  .sh_load(sh_load),
  .sh_use_lzc(sh_use_lzc),
  .lzc_cnt(lzc_cnt),
  .res_exp(res_exp),
  .shift_amt(shift_amt),
  .re_sum(re_sum),
  .sh_sum(sh_sum),
  .re_both_neg(re_both_neg),
  .sh_both_neg(sh_both_neg)
);

// File: tb/fpu_expo_path_test.sv
module fpu_expo_path_test;
  localparam int  CLK_PERIOD = 10;
  localparam int  EW   = 13;
  localparam int  LZW  = 7;
  localparam int  MODV = 1 << EW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [1:0]     re_op1_sel = '0, re_op2_sel = '0, re_kon_sel = '0, sh_op1_sel = '0;
  logic           re_op1_neg = 0, re_op2_neg = 0, re_load = 0;
  logic           sh_op1_neg = 0, sh_op2_neg = 0, sh_op2_sel = 0, sh_use_lzc = 0, sh_load = 0;
  logic [3:0]     sh_kon_sel = '0;
  logic [EW-1:0]  a_exp = '0, b_exp = '0, c_exp = '0;
  logic [LZW-1:0] lzc_cnt = '0;
  logic [EW-1:0]  res_exp, shift_amt;

  int n_cmp = 0;
  int n_bad = 0;
  int m_re  = 0;
  int m_sh  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_expo_path #(.EW(EW), .LZW(LZW)) uut (
    .clk(clk), .rst(rst),
    .re_op1_sel(re_op1_sel), .re_op1_neg(re_op1_neg),
    .re_op2_sel(re_op2_sel), .re_kon_sel(re_kon_sel),
    .re_op2_neg(re_op2_neg), .re_load(re_load),
    .sh_op1_sel(sh_op1_sel), .sh_op1_neg(sh_op1_neg),
    .sh_op2_sel(sh_op2_sel), .sh_kon_sel(sh_kon_sel),
    .sh_op2_neg(sh_op2_neg), .sh_use_lzc(sh_use_lzc), .sh_load(sh_load),
    .a_exp(a_exp), .b_exp(b_exp), .c_exp(c_exp), .lzc_cnt(lzc_cnt),
    .res_exp(res_exp), .shift_amt(shift_amt)
  );

  function automatic int wrap(input int v);
    int r;
    r = v % MODV;
    if (r < 0) r += MODV;
    return r;
  endfunction

  function automatic int as_signed(input int v);
    return (v >= MODV/2) ? v - MODV : v;
  endfunction

  function automatic int exp_const(input int k);
    int tbl [4] = '{0, 56, 1023, 1536};
    return tbl[k];
  endfunction

  function automatic int shift_const(input int k);
    int tbl [10] = '{1, 4, 8, 32, 52, 56, 63, 64, -1022, 0};
    if (k == 0 || k >= 10) return 0;
    return tbl[k-1];
  endfunction

  // Bench's own formulation of the two sums
  function automatic int model_re();
    int x, y;
    case (re_op1_sel)
      0: x = m_re;
      1: x = int'(a_exp);
      2: x = as_signed(int'(b_exp)) >>> 1;
      default: x = 0;
    endcase
    case (re_op2_sel)
      0: y = m_re - m_sh;
      1: y = int'(b_exp);
      2: y = int'(c_exp);
      default: y = exp_const(int'(re_kon_sel));
    endcase
    if (re_op1_neg) x = -x;
    if (re_op2_neg) y = -y;
    return wrap(x + y);
  endfunction

  function automatic int model_sh();
    int x, y;
    case (sh_op1_sel)
      0: x = m_re - m_sh;
      1: x = int'(b_exp);
      2: x = m_sh;
      default: x = 0;
    endcase
    y = sh_op2_sel ? shift_const(int'(sh_kon_sel)) : int'(a_exp);
    if (sh_op1_neg) x = -x;
    if (sh_op2_neg) y = -y;
    return wrap(x + y);
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  // Called just after a falling edge with inputs set; compares one cycle later
  task automatic step();
    int nre, nsh;
    string tre, tsh;
    nre = re_load ? model_re() : m_re;
    nsh = sh_load ? (sh_use_lzc ? int'(lzc_cnt) : model_sh()) : m_sh;
    if (!re_load) tre = "R6 hold";
    else if (re_op1_neg || re_op2_neg) tre = "R5 exp negate";
    else if (re_op2_sel == 2'd3) tre = "R4 exp const";
    else if (re_op2_sel == 2'd0) tre = "R3 exp diff";
    else tre = "R2 exp operand";
    if (!sh_load) tsh = "R10 hold";
    else if (sh_use_lzc) tsh = "R9 lzc bypass";
    else if (sh_op2_sel) tsh = "R8 shift const";
    else tsh = "R7 shift operand";
    @(negedge clk);
    check(tre, int'(res_exp), nre);
    check(tsh, int'(shift_amt), nsh);
    m_re = nre;
    m_sh = nsh;
  endtask

  task automatic rand_data();
    a_exp   = EW'($urandom);
    b_exp   = EW'($urandom);
    c_exp   = EW'($urandom);
    lzc_cnt = LZW'($urandom);
  endtask

  // mode 0: no negation, 1: first operand, 2: second operand
  task automatic rand_neg(input int mode, output logic n1, output logic n2);
    n1 = (mode == 1);
    n2 = (mode == 2);
  endtask

  task automatic rand_controls();
    logic a1, a2;
    re_op1_sel = 2'($urandom); re_op2_sel = 2'($urandom); re_kon_sel = 2'($urandom);
    rand_neg(int'($urandom % 3), a1, a2); re_op1_neg = a1; re_op2_neg = a2;
    sh_op1_sel = 2'($urandom); sh_op2_sel = 1'($urandom); sh_kon_sel = 4'($urandom);
    rand_neg(int'($urandom % 3), a1, a2); sh_op1_neg = a1; sh_op2_neg = a2;
    re_load = 1'($urandom); sh_load = 1'($urandom); sh_use_lzc = 1'($urandom);
  endtask

  // Load both registers with random values via B
  task automatic seed_regs();
    b_exp = EW'($urandom);
    re_op1_sel = 2'd3; re_op2_sel = 2'd1; re_op1_neg = 0; re_op2_neg = 0; re_load = 1;
    sh_op1_sel = 2'd1; sh_op2_sel = 1'b1; sh_kon_sel = 4'd0;
    sh_op1_neg = 0; sh_op2_neg = 0; sh_use_lzc = 0; sh_load = 1;
    step();
    // give shift a different value than res_exp
    re_load = 0;
    b_exp = EW'($urandom);
    step();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic a1, a2;
    rand_data();
    repeat (3) @(negedge clk);
    check("R1 reset exp", int'(res_exp), 0);
    check("R1 reset shift", int'(shift_amt), 0);
    rst = 0;

    // Exponent path sweep
    for (int o1 = 0; o1 < 4; o1++)
      for (int o2 = 0; o2 < 4; o2++)
        for (int k = 0; k < 4; k++)
          for (int nm = 0; nm < 3; nm++) begin
            seed_regs();
            rand_data();
            re_op1_sel = 2'(o1); re_op2_sel = 2'(o2); re_kon_sel = 2'(k);
            rand_neg(nm, a1, a2); re_op1_neg = a1; re_op2_neg = a2;
            re_load = 1; sh_load = 0;
            step();
          end

    // Shift path sweep, including undefined constant codes
    for (int o1 = 0; o1 < 4; o1++)
      for (int o2 = 0; o2 < 2; o2++)
        for (int k = 0; k < 16; k++)
          for (int nm = 0; nm < 3; nm++) begin
            seed_regs();
            rand_data();
            sh_op1_sel = 2'(o1); sh_op2_sel = 1'(o2); sh_kon_sel = 4'(k);
            rand_neg(nm, a1, a2); sh_op1_neg = a1; sh_op2_neg = a2;
            sh_use_lzc = 0; sh_load = 1; re_load = 0;
            step();
          end

    // Boundary: most negative B halved, extremes of lzc
    seed_regs();
    b_exp = EW'(1 << (EW-1));
    re_op1_sel = 2'd2; re_op2_sel = 2'd3; re_kon_sel = 2'd0; re_load = 1;
    lzc_cnt = '1; sh_use_lzc = 1; sh_load = 1;
    sh_op1_neg = 1; sh_op2_neg = 0;
    step();
    lzc_cnt = '0;
    step();

    // Random phase, all controls random
    for (int i = 0; i < 4000; i++) begin
      rand_data();
      rand_controls();
      step();
    end

    // Reset in mid-run
    rst = 1;
    @(negedge clk);
    check("R1 reset exp", int'(res_exp), 0);
    check("R1 reset shift", int'(shift_amt), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule